// File: doc/BRIEF.md
# Multi-level overcurrent protection sequencer

This block is the digital part of a battery-pack discharge guard. It runs from a slow clock of roughly 3.5 kHz. Its inputs are already-synchronised comparator flags: three graded overcurrent levels, one undervoltage flag and one flag that says the load has been released. A level only counts once its flag has stayed high for its own run of clock cycles. When a level counts, the block latches a fault and asks for the load-sense node to be pulled to ground. It also switches the discharge-switch drive to the fault level.

The level-1 and level-2 delays are powers of two of the clock period, set by exponent parameters. The level-2 delay is measured from the moment the level-1 flag rises, not from the moment level 2 itself appears. A heavy surge that arrives late therefore trips at once. An overcurrent fault stays latched until the release flag reports that the load is gone. An undervoltage fault clears as soon as its flag drops. Whether level 3 is used, and the polarity of the drive output, are both parameters. The drive output is a drive-enable plus a level, so the pad outside the block can be tri-stated.

Top module: `ocp_sequencer`

## Requirements
- R1: On a clock edge with `rst` high, the block returns to the normal state. In the normal state `sense_pd` is 0, `drv_lvl` is 0, and `drv_en` is 0 with ACT_HIGH=0 or 1 with ACT_HIGH=1.
- R2: In the normal state, `oc1_flag` that is high on 2^L1_EXP consecutive clock edges gives the overcurrent state at the last of those edges. A single low cycle restarts the count.
- R3: The level-2 timer counts edges on which `oc1_flag` or `oc2_flag` is high. It restarts only when both are low. The overcurrent state is entered at the first edge where `oc2_flag` is high and the timer has reached 2^L2_EXP edges. If level 2 arrives after that many edges, it trips at once.
- R4: With L3_EN=1, `oc3_flag` high on L3_DLY consecutive edges gives the overcurrent state. With L3_EN=0, `oc3_flag` has no effect on the state.
- R5: The overcurrent state is held on every edge where `load_gone` is 0. It goes back to normal on the first edge where `load_gone` is 1. All delay counts restart from zero afterwards, and the overcurrent state never moves straight to undervoltage.
- R6: In the normal state, `uv_flag` high on UV_DLY consecutive edges gives the undervoltage state. That state returns to normal on the first edge where `uv_flag` is low.
- R7: When an overcurrent delay and the undervoltage delay complete on the same edge, the overcurrent state wins.
- R8: `sense_pd` is 1 exactly while the state is overcurrent or undervoltage.
- R9: `drv_lvl` is always 0. With ACT_HIGH=0, `drv_en` is 1 in a fault and 0 in the normal state. With ACT_HIGH=1, it is the other way round.
- R10: `state` encodes normal as 0, overcurrent as 1 and undervoltage as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock, about 3.5 kHz |
| rst | input | 1 | Synchronous active-high reset |
| oc1_flag | input | 1 | Level-1 (lightest) overcurrent comparator flag |
| oc2_flag | input | 1 | Level-2 overcurrent comparator flag |
| oc3_flag | input | 1 | Level-3 (short-circuit) comparator flag |
| uv_flag | input | 1 | Supply undervoltage comparator flag |
| load_gone | input | 1 | High when the supply-to-load-node voltage is at or above the release threshold |
| drv_en | output | 1 | Drive enable for the discharge-switch pad |
| drv_lvl | output | 1 | Level driven onto the pad while `drv_en` is high |
| sense_pd | output | 1 | Request to pull the load-sense node to ground |
| state | output | 2 | Controller state: 0 normal, 1 overcurrent, 2 undervoltage |

## Verification
The bench builds two instances side by side.

- The first uses a level-1 delay of 8 edges, a level-2 delay of 2, level 3 enabled with a one-edge delay, an undervoltage delay of 5 and active-low drive.
- The second uses a level-1 delay of 4, a level-2 delay of 1, level 3 disabled, an undervoltage delay of 3 and active-high drive.

These short delays make every boundary reachable within a few cycles. The exact trip edges, a late level-2 arrival, and overcurrent and undervoltage completing on the same edge can all be checked this way. The pair of instances also covers both polarities and both level-3 options. The differing delays mean the same stimulus puts the two instances in different states at the same time.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_OVERCUR = 2'd1,
        ST_UNDERV  = 2'd2
    } ocp_state_e;

    // Completed-delay indications handed from the timers to the state machine
    typedef struct packed {
        logic lvl1;
        logic lvl2;
        logic lvl3;
        logic uv;
    } ocp_trip_t;

    // Counter width able to hold the value dly-1, never less than one bit
    function automatic int unsigned cnt_width(input int unsigned dly);
        int unsigned w;
        w = (dly > 1) ? $clog2(dly) : 1;
        return w;
    endfunction

    function automatic logic in_fault(input ocp_state_e s);
        return (s != ST_NORMAL);
    endfunction

endpackage

// File: rtl/ocp_persist_timer.sv
module ocp_persist_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic elapsed
);
    localparam int unsigned CW = ocp_pkg::cnt_width(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    // Counts consecutive edges with run high, saturating at the last value
    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // High on the edge that completes DLY consecutive run cycles, and after
    assign elapsed = run && (cnt == LAST);

endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ocp_trip_t  trip,
    input  logic       load_gone,
    input  logic       uv_flag,
    output ocp_state_e st,
    output logic       tmr_clr
);
    ocp_state_e st_nxt;
    logic       oc_hit;

    assign oc_hit = trip.lvl1 | trip.lvl2 | trip.lvl3;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_NORMAL: begin
                // Overcurrent outranks undervoltage on a shared edge
                if (oc_hit)       st_nxt = ST_OVERCUR;
                else if (trip.uv) st_nxt = ST_UNDERV;
            end
            ST_OVERCUR: if (load_gone) st_nxt = ST_NORMAL;
            ST_UNDERV:  if (!uv_flag)  st_nxt = ST_NORMAL;
            default:    st_nxt = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_NORMAL;
        else     st <= st_nxt;
    end

    // Timers stay empty while a fault is latched, so a fresh delay follows release
    assign tmr_clr = in_fault(st);

endmodule

// File: rtl/ocp_pin_drive.sv
module ocp_pin_drive
    import ocp_pkg::*;
#(
    parameter bit ACT_HIGH = 1'b0
) (
    input  ocp_state_e st,
    output logic       drv_en,
    output logic       drv_lvl,
    output logic       sense_pd
);
    logic fault;

    assign fault    = in_fault(st);
    assign sense_pd = fault;
    assign drv_lvl  = 1'b0;

    generate
        if (ACT_HIGH) begin : g_pol_high
            // Normal: pad pulled low; fault: pad released
            assign drv_en = !fault;
        end else begin : g_pol_low
            // Normal: pad released; fault: pad pulled low
            assign drv_en = fault;
        end
    endgenerate

endmodule

// File: rtl/ocp_sequencer.sv
module ocp_sequencer
    import ocp_pkg::*;
#(
    parameter int unsigned L1_EXP   = 6,
    parameter int unsigned L2_EXP   = 2,
    parameter int unsigned L3_DLY   = 1,
    parameter int unsigned UV_DLY   = 17,
    parameter bit          L3_EN    = 1'b1,
    parameter bit          ACT_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       oc1_flag,
    input  logic       oc2_flag,
    input  logic       oc3_flag,
    input  logic       uv_flag,
    input  logic       load_gone,
    output logic       drv_en,
    output logic       drv_lvl,
    output logic       sense_pd,
    output logic [1:0] state
);
    localparam int unsigned L1_DLY = 1 << L1_EXP;
    localparam int unsigned L2_DLY = 1 << L2_EXP;

    ocp_trip_t  trip;
    ocp_state_e st;
    logic       tmr_clr;
    logic       lvl1_run;
    logic       lvl2_run;
    logic       lvl3_run;
    logic       lvl2_done;

    assign lvl1_run = oc1_flag;
    assign lvl2_run = oc1_flag | oc2_flag;
    assign lvl3_run = oc3_flag & L3_EN;

    ocp_persist_timer #(.DLY(L1_DLY)) u_t1 (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(lvl1_run), .elapsed(trip.lvl1)
    );

    // Started by level 1; level 2 only qualifies the completed window
    ocp_persist_timer #(.DLY(L2_DLY)) u_t2 (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(lvl2_run), .elapsed(lvl2_done)
    );
    assign trip.lvl2 = lvl2_done & oc2_flag;

    ocp_persist_timer #(.DLY(L3_DLY)) u_t3 (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(lvl3_run), .elapsed(trip.lvl3)
    );

    ocp_persist_timer #(.DLY(UV_DLY)) u_tu (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(uv_flag), .elapsed(trip.uv)
    );

    ocp_fault_fsm u_fsm (
        .clk(clk), .rst(rst), .trip(trip), .load_gone(load_gone),
        .uv_flag(uv_flag), .st(st), .tmr_clr(tmr_clr)
    );

    ocp_pin_drive #(.ACT_HIGH(ACT_HIGH)) u_pin (
        .st(st), .drv_en(drv_en), .drv_lvl(drv_lvl), .sense_pd(sense_pd)
    );

    assign state = st;

endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
    parameter bit L3_EN    = 1'b1,
    parameter bit ACT_HIGH = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       oc1_flag,
    input logic       oc2_flag,
    input logic       oc3_flag,
    input logic       uv_flag,
    input logic       load_gone,
    input logic       drv_en,
    input logic       drv_lvl,
    input logic       sense_pd,
    input logic [1:0] state
);
    // R10
    state_code_chk: assert property (@(posedge clk) disable iff (rst) state != 2'd3);

    // R5
    oc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && !load_gone) |=> state == 2'd1);

    // R5
    oc_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && load_gone) |=> state == 2'd0);

    // R5
    no_oc_to_uv_chk: assert property (@(posedge clk) disable iff (rst)
        state == 2'd1 |=> state != 2'd2);

    // R6
    uv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && uv_flag) |=> state == 2'd2);

    // R6
    uv_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && !uv_flag) |=> state == 2'd0);

    // R2
    quiet_stays_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && !oc1_flag && !oc2_flag && !(oc3_flag && L3_EN) && !uv_flag)
        |=> state == 2'd0);

    // R8
    pulldown_chk: assert property (@(posedge clk) disable iff (rst)
        sense_pd == (state != 2'd0));

    // R9
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        drv_en == ((state != 2'd0) ^ ACT_HIGH));

    // R9
    level_low_chk: assert property (@(posedge clk) disable iff (rst) drv_lvl == 1'b0);

endmodule

bind ocp_sequencer ocp_checker #(.L3_EN(L3_EN), .ACT_HIGH(ACT_HIGH)) u_chk (
    .clk(clk), .rst(rst), .oc1_flag(oc1_flag), .oc2_flag(oc2_flag),
    .oc3_flag(oc3_flag), .uv_flag(uv_flag), .load_gone(load_gone),
    .drv_en(drv_en), .drv_lvl(drv_lvl), .sense_pd(sense_pd), .state(state)
);

// File: tb/sim_ocp_sequencer.sv
module sim_ocp_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oc1 = 1'b0, oc2 = 1'b0, oc3 = 1'b0, uv = 1'b0, lg = 1'b0;

    logic       en0, lv0, pd0, en1, lv1, pd1;
    logic [1:0] st0, st1;

    int n_chk = 0;
    int n_err = 0;

    // Per-instance settings: delays in edges, level-3 enable, polarity
    int D1[2] = '{8, 4};
    int D2[2] = '{2, 1};
    int D3[2] = '{1, 1};
    int DU[2] = '{5, 3};
    int L3E[2] = '{1, 0};
    int AH[2] = '{0, 1};

    // Model: consecutive-cycle run lengths and expected state
    int k1[2], k2[2], k3[2], ku[2], mst[2];

    always #5 clk = ~clk;

    ocp_sequencer #(.L1_EXP(3), .L2_EXP(1), .L3_DLY(1), .UV_DLY(5),
                    .L3_EN(1'b1), .ACT_HIGH(1'b0)) u0 (
        .clk(clk), .rst(rst), .oc1_flag(oc1), .oc2_flag(oc2), .oc3_flag(oc3),
        .uv_flag(uv), .load_gone(lg), .drv_en(en0), .drv_lvl(lv0),
        .sense_pd(pd0), .state(st0)
    );

    ocp_sequencer #(.L1_EXP(2), .L2_EXP(0), .L3_DLY(1), .UV_DLY(3),
                    .L3_EN(1'b0), .ACT_HIGH(1'b1)) u1 (
        .clk(clk), .rst(rst), .oc1_flag(oc1), .oc2_flag(oc2), .oc3_flag(oc3),
        .uv_flag(uv), .load_gone(lg), .drv_en(en1), .drv_lvl(lv1),
        .sense_pd(pd1), .state(st1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_drv(input int s, input int ah);
        return ((s != 0) ? 1 : 0) ^ ah;
    endfunction

    task automatic mreset();
        for (int i = 0; i < 2; i++) begin
            k1[i] = 0; k2[i] = 0; k3[i] = 0; ku[i] = 0; mst[i] = 0;
        end
    endtask

    // Next-state from the requirement text, applied before each rising edge
    task automatic mstep(input int i);
        bit t1, t2, t3, tu;
        if (mst[i] == 0) begin
            k1[i] = oc1 ? k1[i] + 1 : 0;
            k2[i] = (oc1 || oc2) ? k2[i] + 1 : 0;
            k3[i] = (oc3 && L3E[i] != 0) ? k3[i] + 1 : 0;
            ku[i] = uv ? ku[i] + 1 : 0;
            t1 = k1[i] >= D1[i];
            t2 = oc2 && (k2[i] >= D2[i]);
            t3 = k3[i] >= D3[i];
            tu = ku[i] >= DU[i];
            if (t1 || t2 || t3) mst[i] = 1;
            else if (tu)        mst[i] = 2;
        end else begin
            if (mst[i] == 1 && lg)  mst[i] = 0;
            if (mst[i] == 2 && !uv) mst[i] = 0;
        end
        if (mst[i] != 0) begin
            k1[i] = 0; k2[i] = 0; k3[i] = 0; ku[i] = 0;
        end
    endtask

    task automatic mcmp();
        chk("R10 u0 state", st0, mst[0]);
        chk("R10 u1 state", st1, mst[1]);
        chk("R9 u0 drv_en", en0, exp_drv(mst[0], AH[0]));
        chk("R9 u1 drv_en", en1, exp_drv(mst[1], AH[1]));
        chk("R9 u0 drv_lvl", lv0, 0);
        chk("R9 u1 drv_lvl", lv1, 0);
        chk("R8 u0 sense_pd", pd0, (mst[0] != 0) ? 1 : 0);
        chk("R8 u1 sense_pd", pd1, (mst[1] != 0) ? 1 : 0);
    endtask

    task automatic cyc(input int n);
        for (int c = 0; c < n; c++) begin
            mstep(0);
            mstep(1);
            @(posedge clk);
            @(negedge clk);
            mcmp();
        end
    endtask

    task automatic flags(input bit a, input bit b, input bit c, input bit u, input bit g);
        oc1 = a; oc2 = b; oc3 = c; uv = u; lg = g;
    endtask

    task automatic release_all();
        flags(0, 0, 0, 0, 1);
        cyc(1);
        lg = 0;
    endtask

    initial begin
        #2_000_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C5E_9A11));
        mreset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state for both polarities
        chk("R1 u0 state", st0, 0);
        chk("R1 u1 state", st1, 0);
        chk("R1 u0 drv_en", en0, 0);
        chk("R1 u1 drv_en", en1, 1);
        chk("R1 u0 sense_pd", pd0, 0);
        chk("R1 u1 sense_pd", pd1, 0);

        // R2 exact trip edge of level 1
        flags(1, 0, 0, 0, 0);
        cyc(3);
        chk("R2 u1 before limit", st1, 0);
        cyc(1);
        chk("R2 u1 at limit", st1, 1);
        chk("R2 u0 still counting", st0, 0);
        cyc(4);
        chk("R2 u0 at limit", st0, 1);
        chk("R9 u0 fault drives", en0, 1);
        chk("R9 u1 fault releases", en1, 0);

        // R5 hold while load present, then release
        oc1 = 0;
        cyc(5);
        chk("R5 u0 held", st0, 1);
        lg = 1;
        cyc(1);
        chk("R5 u0 released", st0, 0);
        lg = 0;

        // R5 counts restart after release even with level 1 still high
        flags(1, 0, 0, 0, 0);
        cyc(10);
        lg = 1;
        cyc(1);
        lg = 0;
        cyc(7);
        chk("R5 u0 fresh delay", st0, 0);
        cyc(1);
        chk("R5 u0 fresh trip", st0, 1);
        release_all();

        // R3 late level 2 trips at once
        flags(1, 0, 0, 0, 0);
        cyc(5);
        chk("R3 u0 pre", st0, 0);
        oc2 = 1;
        cyc(1);
        chk("R3 u0 late level2", st0, 1);
        release_all();

        // R3 early level 2 waits for the window started by level 1
        flags(1, 1, 0, 0, 0);
        cyc(1);
        chk("R3 u0 early wait", st0, 0);
        cyc(1);
        chk("R3 u0 early trip", st0, 2'd1);
        release_all();

        // R4 level 3 enabled vs disabled
        flags(0, 0, 1, 0, 0);
        cyc(1);
        chk("R4 u0 level3 trip", st0, 1);
        cyc(5);
        chk("R4 u1 level3 ignored", st1, 0);
        release_all();

        // R6 undervoltage entry and exit
        flags(0, 0, 0, 1, 0);
        cyc(3);
        chk("R6 u1 uv", st1, 2);
        cyc(1);
        chk("R6 u0 before", st0, 0);
        cyc(1);
        chk("R6 u0 uv", st0, 2);
        uv = 0;
        cyc(1);
        chk("R6 u0 clear", st0, 0);
        chk("R6 u1 clear", st1, 0);

        // R7 simultaneous completion
        flags(0, 0, 0, 1, 0);
        cyc(4);
        oc3 = 1;
        cyc(1);
        chk("R7 u0 priority", st0, 1);
        release_all();

        // R2 a dropout restarts the count
        flags(1, 0, 0, 0, 0);
        cyc(7);
        oc1 = 0;
        cyc(1);
        oc1 = 1;
        cyc(7);
        chk("R2 u0 restart", st0, 0);
        release_all();

        // Random bursts
        for (int r = 0; r < 3000; r++) begin
            if ($urandom % 5 == 0) begin
                oc1 = ($urandom % 3) == 0;
                oc2 = oc1 && (($urandom % 3) == 0);
                oc3 = oc2 && (($urandom % 2) == 0);
                uv  = ($urandom % 5) == 0;
                lg  = ($urandom % 4) == 0;
            end
            cyc(1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule